// File: doc/BRIEF.md
# Color Register and Block-Write Column Engine

This block watches the row strobe, column strobe, write strobe and special-function select of a video-memory port. It recognises two cycle types. A color-load cycle stores the four data lines into a color register. A block-write cycle writes that color value into as many as four neighbouring columns during a single column strobe.

In a block write, the two low column address bits are not used. The four data lines act as a column mask instead. The engine turns the mask into a short burst of single-column write requests for the array controller. Each request carries the column, the color and the per-bit write enables supplied by the neighbouring write-per-bit logic. A done pulse closes every block write. The array itself lies outside this block.

All strobes are active low. The block samples them on its own clock, so a falling edge is a clock where a strobe reads low after reading high on the previous clock.

Top module: `cbw_block_write`

## Requirements
- R1: A write cycle with `dsf` high at the row-strobe fall and also at the column-strobe fall loads `dq[3:0]` into the color register.
- R2: Reset clears the color register to 4'b0000. The register keeps its value through every other kind of cycle until the next color load.
- R3: A write cycle with `dsf` low at the row-strobe fall and high at the column-strobe fall is a block write. Its column bits [8:2] are the ones present at the column-strobe fall, and `col_addr[1:0]` is ignored.
- R4: The mask (or the color, in a load) is taken from `dq` on the first clock where the column strobe and the write strobe both read low, which is the later of their two falls. `wpb_en` is taken on the same clock, and later changes on either input have no effect.
- R5: Mask bit i enables column offset i, and a 1 means write. The enabled columns are requested one per clock in ascending offset order, with `req_col` = {bits [8:2], offset}. The first request appears two clocks after the latch clock.
- R6: Every request of a block write carries `req_data` equal to the color register and `req_bitmask` equal to the captured `wpb_en`.
- R7: `bw_done` pulses for one clock, on the clock after the last request. With mask 4'b0000 there is no request, and `bw_done` pulses two clocks after the latch clock.
- R8: A write cycle with `dsf` low at the column-strobe fall, or a column strobe that falls while the row strobe is high, produces no request and no done pulse, and does not change the color register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| dsf | input | 1 | Special-function select |
| col_addr | input | 9 | Column address |
| dq | input | 4 | Data lines: color value or column mask |
| wpb_en | input | 4 | Per-bit write enables from the write-per-bit logic |
| req_valid | output | 1 | A column-write request is present |
| req_col | output | 9 | Column of the request |
| req_data | output | 4 | Data to write (the color) |
| req_bitmask | output | 4 | Per-bit enables of the request |
| bw_done | output | 1 | One-clock pulse that closes a block write |

## Verification
The assertions assume that a new block write is never latched while the engine still has columns to issue. The stimulus meets this by keeping at least ten idle clocks between the latch clock of one cycle and the row-strobe fall of the next. They also assume that each strobe stays at a level for at least one clock. The stimulus changes strobes only on falling clock edges and holds every level for at least one full period. The bench sweeps every mask and every color, computes the expected column order from the mask bits in arithmetic, and compares each request clock against it.

// File: rtl/cbw_pkg.sv
package cbw_pkg;

   // Cycle kind resolved on the clock where the data lines are latched.
   typedef enum logic [1:0] {
      CYC_NONE  = 2'd0,
      CYC_LOAD  = 2'd1,
      CYC_BLOCK = 2'd2
   } cyc_kind_t;

endpackage

// File: rtl/cbw_strobe_decode.sv
module cbw_strobe_decode
   import cbw_pkg::*;
#(
   parameter int COL_W = 9,
   parameter int OFS_W = 2,
   parameter int DQ_W  = 4,
   localparam int HI_W = COL_W - OFS_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ras_n,
   input  logic             cas_n,
   input  logic             we_n,
   input  logic             dsf,
   input  logic [COL_W-1:0] col_addr,
   input  logic [DQ_W-1:0]  dq,
   input  logic [DQ_W-1:0]  wpb_en,
   output cyc_kind_t        ev_kind,
   output logic [HI_W-1:0]  ev_hi,
   output logic [DQ_W-1:0]  ev_dq,
   output logic [DQ_W-1:0]  ev_wpb
);

   logic            ras_q, cas_q;
   logic            dsf_row_q, dsf_col_q, pend_q;
   logic [HI_W-1:0] hi_q;

   logic            ras_fall, cas_fall, armed, fire;
   logic            dsf_row_eff, dsf_col_eff;
   logic [HI_W-1:0] hi_eff;
   cyc_kind_t       kind_nxt;

   // A column fall counts only while the row strobe is low.
   assign ras_fall    = ras_q & ~ras_n;
   assign cas_fall    = cas_q & ~cas_n & ~ras_n;
   assign dsf_row_eff = ras_fall ? dsf : dsf_row_q;
   assign dsf_col_eff = cas_fall ? dsf : dsf_col_q;
   assign hi_eff      = cas_fall ? col_addr[COL_W-1:OFS_W] : hi_q;

   // Armed from the column fall until the write strobe is also low.
   assign armed = (pend_q | cas_fall) & ~ras_n & ~cas_n;
   assign fire  = armed & ~we_n;

   always_comb begin
      kind_nxt = CYC_NONE;
      if (fire && dsf_col_eff)
         kind_nxt = dsf_row_eff ? CYC_LOAD : CYC_BLOCK;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ras_q     <= 1'b1;
         cas_q     <= 1'b1;
         dsf_row_q <= 1'b0;
         dsf_col_q <= 1'b0;
         pend_q    <= 1'b0;
         hi_q      <= '0;
         ev_kind   <= CYC_NONE;
         ev_hi     <= '0;
         ev_dq     <= '0;
         ev_wpb    <= '0;
      end else begin
         ras_q   <= ras_n;
         cas_q   <= cas_n;
         pend_q  <= armed & we_n;
         ev_kind <= kind_nxt;
         if (ras_fall) dsf_row_q <= dsf;
         if (cas_fall) begin
            dsf_col_q <= dsf;
            hi_q      <= col_addr[COL_W-1:OFS_W];
         end
         if (fire) begin
            ev_hi  <= hi_eff;
            ev_dq  <= dq;
            ev_wpb <= wpb_en;
         end
      end
   end

   AST_EVT_NEEDS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_kind != CYC_NONE) |-> !$past(ras_n)); // R8
   AST_ONE_EVT_PER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_kind != CYC_NONE) |=> (ev_kind == CYC_NONE)); // R4

endmodule

// File: rtl/cbw_color_reg.sv
module cbw_color_reg #(
   parameter int              DQ_W    = 4,
   parameter logic [DQ_W-1:0] RST_VAL = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ld,
   input  logic [DQ_W-1:0] d,
   output logic [DQ_W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= RST_VAL;
      else if (ld) q <= d;
   end

   AST_COLOR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !ld |=> $stable(q)); // R2
   AST_COLOR_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> (q == $past(d))); // R1

endmodule

// File: rtl/cbw_col_issuer.sv
module cbw_col_issuer #(
   parameter int COL_W = 9,
   parameter int OFS_W = 2,
   parameter int DQ_W  = 4,
   localparam int HI_W  = COL_W - OFS_W,
   localparam int LANES = 1 << OFS_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [LANES-1:0] start_mask,
   input  logic [HI_W-1:0]  start_hi,
   input  logic [DQ_W-1:0]  color,
   input  logic [DQ_W-1:0]  wpb,
   output logic             req_valid,
   output logic [COL_W-1:0] req_col,
   output logic [DQ_W-1:0]  req_data,
   output logic [DQ_W-1:0]  req_bitmask,
   output logic             done
);

   logic [LANES-1:0] rem_q, pick;
   logic [LANES:0]   lower_any;
   logic [HI_W-1:0]  hi_q;
   logic [DQ_W-1:0]  data_q, be_q;
   logic [OFS_W-1:0] ofs;

   // Lowest remaining lane wins: it is the next ascending offset.
   assign lower_any[0] = 1'b0;
   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign pick[i]        = rem_q[i] & ~lower_any[i];
      assign lower_any[i+1] = lower_any[i] | rem_q[i];
   end

   always_comb begin
      ofs = '0;
      for (int i = 0; i < LANES; i++)
         if (pick[i]) ofs = OFS_W'(i);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q  <= '0;
         hi_q   <= '0;
         data_q <= '0;
         be_q   <= '0;
         done   <= 1'b0;
      end else if (start) begin
         rem_q  <= start_mask;
         hi_q   <= start_hi;
         data_q <= color;
         be_q   <= wpb;
         done   <= (start_mask == '0);
      end else begin
         rem_q <= rem_q & ~pick;
         done  <= (rem_q != '0) && ((rem_q & ~pick) == '0);
      end
   end

   assign req_valid   = |rem_q;
   assign req_col     = {hi_q, ofs};
   assign req_data    = data_q;
   assign req_bitmask = be_q;

   AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !req_valid); // R3
   AST_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && $past(req_valid)) |-> (req_col[OFS_W-1:0] > $past(req_col[OFS_W-1:0]))); // R5
   AST_PAYLOAD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && $past(req_valid)) |-> ($stable(req_data) && $stable(req_bitmask)
                                           && $stable(req_col[COL_W-1:OFS_W]))); // R6
   AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && ($countones(rem_q) == 1) && !start) |=> done); // R7
   AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !req_valid); // R7

endmodule

// File: rtl/cbw_block_write.sv
module cbw_block_write
   import cbw_pkg::*;
#(
   parameter int COL_W = 9,
   parameter int OFS_W = 2,
   parameter int DQ_W  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ras_n,
   input  logic             cas_n,
   input  logic             we_n,
   input  logic             dsf,
   input  logic [COL_W-1:0] col_addr,
   input  logic [DQ_W-1:0]  dq,
   input  logic [DQ_W-1:0]  wpb_en,
   output logic             req_valid,
   output logic [COL_W-1:0] req_col,
   output logic [DQ_W-1:0]  req_data,
   output logic [DQ_W-1:0]  req_bitmask,
   output logic             bw_done
);

   localparam int HI_W  = COL_W - OFS_W;
   localparam int LANES = 1 << OFS_W;

   if (DQ_W != LANES) begin : g_bad_lanes
      $error("cbw_block_write: DQ_W must equal 2**OFS_W");
   end
   if (COL_W <= OFS_W) begin : g_bad_col
      $error("cbw_block_write: COL_W must exceed OFS_W");
   end

   cyc_kind_t       ev_kind;
   logic [HI_W-1:0] ev_hi;
   logic [DQ_W-1:0] ev_dq, ev_wpb, color;

   cbw_strobe_decode #(.COL_W(COL_W), .OFS_W(OFS_W), .DQ_W(DQ_W)) u_dec (
      .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
      .dsf(dsf), .col_addr(col_addr), .dq(dq), .wpb_en(wpb_en),
      .ev_kind(ev_kind), .ev_hi(ev_hi), .ev_dq(ev_dq), .ev_wpb(ev_wpb)
   );

   cbw_color_reg #(.DQ_W(DQ_W)) u_color (
      .clk(clk), .rst_n(rst_n), .ld(ev_kind == CYC_LOAD), .d(ev_dq), .q(color)
   );

   cbw_col_issuer #(.COL_W(COL_W), .OFS_W(OFS_W), .DQ_W(DQ_W)) u_iss (
      .clk(clk), .rst_n(rst_n), .start(ev_kind == CYC_BLOCK),
      .start_mask(ev_dq[LANES-1:0]), .start_hi(ev_hi), .color(color), .wpb(ev_wpb),
      .req_valid(req_valid), .req_col(req_col), .req_data(req_data),
      .req_bitmask(req_bitmask), .done(bw_done)
   );

endmodule

// File: tb/cbw_block_write_test.sv
`timescale 1ns/1ps
module cbw_block_write_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, dsf = 1'b0;
   logic [8:0] col_addr = '0;
   logic [3:0] dq = '0, wpb_en = '0;
   logic       req_valid, bw_done;
   logic [8:0] req_col;
   logic [3:0] req_data, req_bitmask;

   int n_chk = 0, n_bad = 0, cyc = 0;
   logic [3:0] color_model = 4'h0;

   always #2 clk = ~clk;

   cbw_block_write uut (
      .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
      .dsf(dsf), .col_addr(col_addr), .dq(dq), .wpb_en(wpb_en),
      .req_valid(req_valid), .req_col(req_col), .req_data(req_data),
      .req_bitmask(req_bitmask), .bw_done(bw_done)
   );

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: run hung, act=%0d exp<150000 cycles", cyc);
         summary();
         $finish;
      end
   end

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: act=%0h exp=%0h", tag, what, act, expv);
      end
   endtask

   // Sample 8 windows after the latch clock. Requests appear in windows 2..2+n-1
   // and done in window 2+n when is_blk is set; otherwise the outputs stay quiet.
   task automatic observe(input string tag, input bit is_blk, input logic [6:0] hi,
                          input logic [3:0] mask, input logic [3:0] col_exp,
                          input logic [3:0] be_exp);
      int ofs[4];
      int n = 0;
      for (int i = 0; i < 4; i++) if (is_blk && mask[i]) begin ofs[n] = i; n++; end
      for (int k = 1; k <= 8; k++) begin
         bit ev, ed;
         @(negedge clk);
         ev = (k >= 2) && (k < 2 + n);
         ed = is_blk && (k == 2 + n);
         chk(req_valid === ev, tag, $sformatf("req_valid w%0d", k), req_valid, ev);
         chk(bw_done === ed, tag, $sformatf("bw_done w%0d", k), bw_done, ed);
         if (ev) begin
            int ec = hi * 4 + ofs[k-2];
            chk(req_col === 9'(ec), tag, "req_col", req_col, ec);
            chk(req_data === col_exp && req_bitmask === be_exp, tag, "data/bitmask",
                {req_data, req_bitmask}, {col_exp, be_exp});
         end
      end
   endtask

   task automatic idle();
      ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; dsf = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   // One strobe cycle; with late set, the write strobe falls a clock after CAS,
   // and dq, wpb_en and col_addr change in between.
   task automatic run_cycle(input string tag, input bit dr, input bit dc,
                            input logic [8:0] col, input logic [3:0] dqv,
                            input logic [3:0] wpbv, input bit late);
      bit is_blk = !dr && dc;
      bit is_ld  = dr && dc;
      @(negedge clk);
      ras_n = 1'b0; dsf = dr;
      @(negedge clk);
      cas_n = 1'b0; dsf = dc; col_addr = col;
      dq     = late ? ~dqv : dqv;
      wpb_en = late ? ~wpbv : wpbv;
      we_n   = late;
      if (late) begin
         @(negedge clk);
         dq = dqv; wpb_en = wpbv; we_n = 1'b0; col_addr = ~col; dsf = ~dc;
      end
      observe(tag, is_blk, col[8:2], dqv, color_model, wpbv);
      if (is_ld) color_model = dqv;
      idle();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R2: reset state, outputs quiet
      chk(req_valid === 1'b0 && bw_done === 1'b0, "R2", "reset outputs",
          {req_valid, bw_done}, 0);
      // R2: color is zero after reset, seen through a full-mask block write
      run_cycle("R2", 1'b0, 1'b1, 9'h1A4, 4'hF, 4'hF, 1'b0);

      // R1/R5/R6: every color loaded, then a block write with a varied mask
      for (int c = 0; c < 16; c++) begin
         run_cycle("R1", 1'b1, 1'b1, 9'h000, 4'(c), 4'h0, 1'b0);
         run_cycle("R6", 1'b0, 1'b1, 9'(c * 29 + 4), 4'((c * 7 + 3) & 15), 4'(~c), 1'b0);
      end

      // R5/R7: all sixteen masks, mask 0 included, low address bits nonzero (R3)
      run_cycle("R1", 1'b1, 1'b1, 9'h000, 4'hA, 4'h0, 1'b0);
      for (int m = 0; m < 16; m++)
         run_cycle(m == 0 ? "R7" : "R5", 1'b0, 1'b1, 9'(m * 32 + (m & 3)), 4'(m), 4'(m ^ 5), 1'b0);

      // R3: column bits sampled at CAS fall, low bits ignored
      run_cycle("R3", 1'b0, 1'b1, 9'h1FF, 4'h9, 4'h3, 1'b0);

      // R4: write strobe falls after CAS; later values of dq and wpb_en are taken
      run_cycle("R4", 1'b0, 1'b1, 9'h0C6, 4'h6, 4'hC, 1'b1);
      run_cycle("R4", 1'b1, 1'b1, 9'h000, 4'h5, 4'h0, 1'b1);
      run_cycle("R4", 1'b0, 1'b1, 9'h155, 4'hF, 4'h1, 1'b1);

      // R8: ordinary writes (dsf low at CAS) leave everything untouched
      run_cycle("R8", 1'b1, 1'b0, 9'h0F0, 4'h3, 4'h0, 1'b0);
      run_cycle("R8", 1'b0, 1'b0, 9'h0F0, 4'hC, 4'h0, 1'b0);
      run_cycle("R2", 1'b0, 1'b1, 9'h088, 4'hF, 4'h7, 1'b0);

      // R8: column strobe before row strobe, dsf high, write strobe low
      @(negedge clk);
      cas_n = 1'b0; we_n = 1'b0; dsf = 1'b1; dq = 4'hE;
      @(negedge clk);
      ras_n = 1'b0;
      observe("R8", 1'b0, 7'h0, 4'h0, 4'h0, 4'h0);
      idle();
      run_cycle("R8", 1'b0, 1'b1, 9'h040, 4'hF, 4'h2, 1'b0);

      summary();
      $finish;
   end

endmodule